// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block sits between a clocked system bus and an external asynchronous static RAM of 256K bytes. It takes one word per request through a valid/ready handshake and turns each request into a strobe sequence that meets the memory's minimum timings. The memory has a select pair of opposite polarity (one active low, one active high), an active-low write strobe, an active-low output enable and a shared data bus. The controller drives that bus through a separate output value and a drive-enable, so the tri-state buffer itself lives in the pad ring.

Every timing is a parameter in picoseconds and is turned into whole clock cycles by rounding up over the clock period. The write window, where both selects and the write strobe are all active, is held for the longest of the pulse-width, select-to-end, address-to-end and data-setup figures. Address and write data stay stable across that window and through the recovery cycles. A read holds the selects and output enable for the access time, captures the bus into a register and pulses a data-valid flag. When a read follows a write, or a write follows a read, the controller first leaves the bus idle for the high-impedance delay so that the memory and the controller never drive it at once. A parameter picks whether the selects stay active through write recovery, which makes write enable the strobe that ends the window, or fall together with write enable.

Top module: `async_sram_ctrl`

## Requirements
- R1: After reset and whenever `req_ready` is high, `mem_sel_n` is 1, `mem_sel` is 0, `mem_we_n` is 1, `mem_oe_n` is 1 and `mem_dq_oe` is 0. In every cycle `mem_sel_n` equals the inverse of `mem_sel`.
- R2: A request is taken at a rising edge where `req_valid` and `req_ready` are both 1, and `req_ready` is 0 in the following cycle. A request presented while `req_ready` is 0 writes nothing and reads nothing.
- R3: A write holds `mem_we_n` low with both selects active for exactly WP cycles, where WP is the largest of the rounded-up write-pulse, select-to-end, address-to-end and data-setup times (6 at defaults). `mem_addr` and `mem_dq_out` do not change inside the window.
- R4: With no turnaround, `req_ready` is low for WC cycles after a write is accepted, where WC is the larger of the rounded-up write cycle time and WP+1 (7 at defaults). During those cycles `mem_dq_oe` is 1 from the first window cycle to the last recovery cycle.
- R5: A read holds both selects active, `mem_we_n` high and `mem_oe_n` low for RD cycles, where RD is the larger of the rounded-up read cycle and access times (7 at defaults). `req_ready` is low for RD cycles after acceptance.
- R6: `mem_dq_oe` is never 1 in a cycle where `mem_oe_n` is 0.
- R7: When the access direction changes, at least TURN cycles (the rounded-up high-impedance delay, 3 at defaults) pass with neither `mem_dq_oe` high nor `mem_oe_n` low. Each cycle of this gap adds one to the busy time in R4 and R5.
- R8: With `WIN_BY_WE` = 1 (default), the selects stay active in the write recovery cycles while `mem_we_n` is high, so the window is ended by write enable. With 0, the selects fall together with write enable.
- R9: `rd_data` holds the byte on `mem_dq_in` at the edge that ends the access count. It equals the last byte written to that address. `rd_valid` is 1 for exactly one cycle: the first cycle after the output enable is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 8 | Write byte |
| req_ready | output | 1 | Controller idle, request can be taken |
| rd_data | output | 8 | Captured read byte |
| rd_valid | output | 1 | One-cycle pulse: rd_data is new |
| mem_addr | output | 18 | Memory address pins |
| mem_sel_n | output | 1 | Active-low memory select |
| mem_sel | output | 1 | Active-high memory select |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_dq_out | output | 8 | Value driven onto the data bus |
| mem_dq_oe | output | 1 | Drive enable for the data bus |
| mem_dq_in | input | 8 | Value read from the data bus |

## Verification
All memory strobes come from flops loaded with the next state, so a write window opens in the first cycle after the accepting edge and lasts WP cycles. `req_ready` returns WC cycles after acceptance, plus TURN when the direction flips. The read strobes likewise start in the first cycle after acceptance, and `rd_valid` appears in the cycle just after the RD-th strobed cycle. The bench samples every output on the falling edge and measures run lengths and gaps with counters. It also counts busy cycles after each acceptance, so each result is checked in exactly the cycle it is due.

// File: rtl/async_sram_pkg.sv
package async_sram_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_TURN,
      ST_WRP,
      ST_WRH,
      ST_RD
   } seq_state_t;

   function automatic int unsigned ps_to_cyc(input int unsigned t_ps, input int unsigned clk_ps);
      return (t_ps + clk_ps - 1) / clk_ps;
   endfunction

   function automatic int unsigned umax(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/asram_seq.sv
module asram_seq
   import async_sram_pkg::*;
#(
   parameter int unsigned WP_CYC   = 6,
   parameter int unsigned WH_CYC   = 1,
   parameter int unsigned RD_CYC   = 7,
   parameter int unsigned AA_CYC   = 7,
   parameter int unsigned TURN_CYC = 3,
   parameter int unsigned CW       = 3
)(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req_valid,
   input  logic       req_write,
   output logic       req_ready,
   output logic       accept,
   output logic       cap,
   output seq_state_t st_nx
);
   localparam logic [CW-1:0] L_WP   = CW'(WP_CYC - 1);
   localparam logic [CW-1:0] L_WH   = CW'(WH_CYC - 1);
   localparam logic [CW-1:0] L_RD   = CW'(RD_CYC - 1);
   localparam logic [CW-1:0] L_AA   = CW'(AA_CYC - 1);
   localparam logic [CW-1:0] L_TURN = CW'((TURN_CYC > 0) ? TURN_CYC - 1 : 0);
   localparam bit            HAS_TURN = (TURN_CYC > 0);

   seq_state_t      st_q, nx;
   logic [CW-1:0]   cnt_q, cnt_nx;
   logic            pend_wr_q, last_wr_q, last_vld_q;

   assign req_ready = (st_q == ST_IDLE);
   assign accept    = req_valid && req_ready;
   assign st_nx     = nx;

   always_comb begin
      nx     = st_q;
      cnt_nx = cnt_q + 1'b1;
      cap    = 1'b0;
      unique case (st_q)
         ST_IDLE: begin
            cnt_nx = '0;
            if (accept) begin
               if (HAS_TURN && last_vld_q && (last_wr_q != req_write))
                  nx = ST_TURN;
               else
                  nx = req_write ? ST_WRP : ST_RD;
            end
         end
         ST_TURN: begin
            if (cnt_q == L_TURN) begin
               cnt_nx = '0;
               nx     = pend_wr_q ? ST_WRP : ST_RD;
            end
         end
         ST_WRP: begin
            if (cnt_q == L_WP) begin
               cnt_nx = '0;
               nx     = ST_WRH;
            end
         end
         ST_WRH: begin
            if (cnt_q == L_WH) begin
               cnt_nx = '0;
               nx     = ST_IDLE;
            end
         end
         ST_RD: begin
            if (cnt_q == L_AA) cap = 1'b1;
            if (cnt_q == L_RD) begin
               cnt_nx = '0;
               nx     = ST_IDLE;
            end
         end
         default: begin
            cnt_nx = '0;
            nx     = ST_IDLE;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= ST_IDLE;
         cnt_q      <= '0;
         pend_wr_q  <= 1'b0;
         last_wr_q  <= 1'b0;
         last_vld_q <= 1'b0;
      end else begin
         st_q  <= nx;
         cnt_q <= cnt_nx;
         if (accept) begin
            pend_wr_q  <= req_write;
            last_wr_q  <= req_write;
            last_vld_q <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/asram_strobe.sv
module asram_strobe
   import async_sram_pkg::*;
#(
   parameter bit WIN_BY_WE = 1'b1
)(
   input  logic       clk,
   input  logic       rst_n,
   input  seq_state_t st_nx,
   output logic       sel_n_o,
   output logic       sel_o,
   output logic       we_n_o,
   output logic       oe_n_o,
   output logic       dq_oe_o
);
   logic sel_nx, we_nx, oe_nx, dq_nx;

   generate
      if (WIN_BY_WE) begin : g_we_bounded
         assign sel_nx = (st_nx == ST_WRP) || (st_nx == ST_WRH) || (st_nx == ST_RD);
      end else begin : g_sel_bounded
         assign sel_nx = (st_nx == ST_WRP) || (st_nx == ST_RD);
      end
   endgenerate

   assign we_nx = (st_nx == ST_WRP);
   assign oe_nx = (st_nx == ST_RD);
   assign dq_nx = (st_nx == ST_WRP) || (st_nx == ST_WRH);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_n_o <= 1'b1;
         sel_o   <= 1'b0;
         we_n_o  <= 1'b1;
         oe_n_o  <= 1'b1;
         dq_oe_o <= 1'b0;
      end else begin
         sel_n_o <= !sel_nx;
         sel_o   <= sel_nx;
         we_n_o  <= !we_nx;
         oe_n_o  <= !oe_nx;
         dq_oe_o <= dq_nx;
      end
   end

endmodule

// File: rtl/asram_datapath.sv
module asram_datapath #(
   parameter int unsigned ADDR_W = 18,
   parameter int unsigned DATA_W = 8
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic              cap,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [DATA_W-1:0] mem_dq_in,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_dq_out,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_valid
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_addr   <= '0;
         mem_dq_out <= '0;
         rd_data    <= '0;
         rd_valid   <= 1'b0;
      end else begin
         if (accept) begin
            mem_addr   <= req_addr;
            mem_dq_out <= req_wdata;
         end
         if (cap) rd_data <= mem_dq_in;
         rd_valid <= cap;
      end
   end

endmodule

// File: rtl/async_sram_ctrl.sv
module async_sram_ctrl
   import async_sram_pkg::*;
#(
   parameter int unsigned ADDR_W    = 18,
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned CLK_PS    = 8000,
   parameter int unsigned T_RC_PS   = 55000,
   parameter int unsigned T_AA_PS   = 55000,
   parameter int unsigned T_WC_PS   = 55000,
   parameter int unsigned T_WP_PS   = 40000,
   parameter int unsigned T_CW_PS   = 45000,
   parameter int unsigned T_AW_PS   = 45000,
   parameter int unsigned T_DW_PS   = 25000,
   parameter int unsigned T_HZ_PS   = 20000,
   parameter bit          WIN_BY_WE = 1'b1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              req_ready,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_valid,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_sel_n,
   output logic              mem_sel,
   output logic              mem_we_n,
   output logic              mem_oe_n,
   output logic [DATA_W-1:0] mem_dq_out,
   output logic              mem_dq_oe,
   input  logic [DATA_W-1:0] mem_dq_in
);
   localparam int unsigned AA_CYC   = umax(1, ps_to_cyc(T_AA_PS, CLK_PS));
   localparam int unsigned RD_CYC   = umax(AA_CYC, ps_to_cyc(T_RC_PS, CLK_PS));
   localparam int unsigned WP_CYC   = umax(1, umax(umax(ps_to_cyc(T_WP_PS, CLK_PS), ps_to_cyc(T_CW_PS, CLK_PS)),
                                                   umax(ps_to_cyc(T_AW_PS, CLK_PS), ps_to_cyc(T_DW_PS, CLK_PS))));
   localparam int unsigned WC_CYC   = umax(WP_CYC + 1, ps_to_cyc(T_WC_PS, CLK_PS));
   localparam int unsigned WH_CYC   = WC_CYC - WP_CYC;
   localparam int unsigned TURN_CYC = ps_to_cyc(T_HZ_PS, CLK_PS);
   localparam int unsigned MAX_CYC  = umax(umax(RD_CYC, WP_CYC), umax(WH_CYC, TURN_CYC));
   localparam int unsigned CW       = $clog2(MAX_CYC + 1);

   generate
      if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
         $error("async_sram_ctrl: address and data widths must be nonzero");
      end
      if (CLK_PS == 0) begin : g_bad_clk
         $error("async_sram_ctrl: clock period must be nonzero");
      end
   endgenerate

   logic       accept, cap;
   seq_state_t st_nx;

   asram_seq #(
      .WP_CYC   (WP_CYC),
      .WH_CYC   (WH_CYC),
      .RD_CYC   (RD_CYC),
      .AA_CYC   (AA_CYC),
      .TURN_CYC (TURN_CYC),
      .CW       (CW)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_write (req_write),
      .req_ready (req_ready),
      .accept    (accept),
      .cap       (cap),
      .st_nx     (st_nx)
   );

   asram_strobe #(
      .WIN_BY_WE (WIN_BY_WE)
   ) u_strobe (
      .clk     (clk),
      .rst_n   (rst_n),
      .st_nx   (st_nx),
      .sel_n_o (mem_sel_n),
      .sel_o   (mem_sel),
      .we_n_o  (mem_we_n),
      .oe_n_o  (mem_oe_n),
      .dq_oe_o (mem_dq_oe)
   );

   asram_datapath #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_dp (
      .clk        (clk),
      .rst_n      (rst_n),
      .accept     (accept),
      .cap        (cap),
      .req_addr   (req_addr),
      .req_wdata  (req_wdata),
      .mem_dq_in  (mem_dq_in),
      .mem_addr   (mem_addr),
      .mem_dq_out (mem_dq_out),
      .rd_data    (rd_data),
      .rd_valid   (rd_valid)
   );

endmodule

// File: rtl/async_sram_ctrl_chk.sv
module async_sram_ctrl_chk
   import async_sram_pkg::*;
#(
   parameter int unsigned ADDR_W  = 18,
   parameter int unsigned DATA_W  = 8,
   parameter int unsigned CLK_PS  = 8000,
   parameter int unsigned T_WP_PS = 40000,
   parameter int unsigned T_CW_PS = 45000,
   parameter int unsigned T_AW_PS = 45000,
   parameter int unsigned T_DW_PS = 25000
)(
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic              rd_valid,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [DATA_W-1:0] mem_dq_out,
   input logic              mem_sel_n,
   input logic              mem_sel,
   input logic              mem_we_n,
   input logic              mem_oe_n,
   input logic              mem_dq_oe
);
   localparam int unsigned WP_CYC = umax(1, umax(umax(ps_to_cyc(T_WP_PS, CLK_PS), ps_to_cyc(T_CW_PS, CLK_PS)),
                                                 umax(ps_to_cyc(T_AW_PS, CLK_PS), ps_to_cyc(T_DW_PS, CLK_PS))));

   logic [15:0] we_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         we_run <= '0;
      else if (!mem_we_n) we_run <= we_run + 16'd1;
      else                we_run <= '0;
   end

   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (mem_sel_n && !mem_sel && mem_we_n && mem_oe_n && !mem_dq_oe));

   a_r1_sel_pair: assert property (@(posedge clk) disable iff (!rst_n)
      mem_sel_n == !mem_sel);

   a_r2_take_drops_ready: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

   a_r3_window_selected: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> (!mem_sel_n && mem_sel && mem_dq_oe));

   a_r3_window_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_we_n && $past(!mem_we_n)) |-> ($stable(mem_addr) && $stable(mem_dq_out)));

   a_r3_pulse_len: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |-> (we_run == 16'(WP_CYC)));

   a_r6_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
      mem_dq_oe |-> mem_oe_n);

   a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |=> !rd_valid);

endmodule

bind async_sram_ctrl async_sram_ctrl_chk #(
   .ADDR_W  (ADDR_W),
   .DATA_W  (DATA_W),
   .CLK_PS  (CLK_PS),
   .T_WP_PS (T_WP_PS),
   .T_CW_PS (T_CW_PS),
   .T_AW_PS (T_AW_PS),
   .T_DW_PS (T_DW_PS)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .req_ready  (req_ready),
   .rd_valid   (rd_valid),
   .mem_addr   (mem_addr),
   .mem_dq_out (mem_dq_out),
   .mem_sel_n  (mem_sel_n),
   .mem_sel    (mem_sel),
   .mem_we_n   (mem_we_n),
   .mem_oe_n   (mem_oe_n),
   .mem_dq_oe  (mem_dq_oe)
);

// File: tb/async_sram_ctrl_bench.sv
module async_sram_ctrl_bench;
   // Expected cycle counts for a 125 MHz clock (8 ns), worked out by hand
   localparam int WP   = 6;   // max of 40, 45, 45, 25 ns over 8 ns, rounded up
   localparam int WC   = 7;   // 55 ns over 8 ns
   localparam int RD   = 7;   // 55 ns over 8 ns
   localparam int TURN = 3;   // 20 ns over 8 ns

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0;
   logic [17:0] req_addr = '0;
   logic [7:0]  req_wdata = '0;
   logic        req_ready, rd_valid;
   logic [7:0]  rd_data;
   logic [17:0] mem_addr;
   logic        mem_sel_n, mem_sel, mem_we_n, mem_oe_n, mem_dq_oe;
   logic [7:0]  mem_dq_out;
   logic [7:0]  mem_dq_in = 8'hEE;

   int tests = 0, fails = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   async_sram_ctrl u_async_sram_ctrl (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
      .rd_data(rd_data), .rd_valid(rd_valid), .mem_addr(mem_addr),
      .mem_sel_n(mem_sel_n), .mem_sel(mem_sel), .mem_we_n(mem_we_n),
      .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
      .mem_dq_in(mem_dq_in)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // ---------------- cycle model of the memory and its timing rules ----------
   logic [7:0]  model_mem [logic [17:0]];
   logic [7:0]  shadow    [logic [17:0]];
   logic [7:0]  exp_q[$];
   int          we_run = 0, oe_run = 0, since_drive = 0, since_oe = 0;
   bit          drove = 0, seen_oe = 0, prev_win = 0, prev_rd = 0, prev_dqoe = 0;
   logic        win, rden, ended;
   logic [17:0] win_addr;
   logic [7:0]  win_data;

   always @(negedge clk) begin
      if (rst_n && !done) begin
         win  = !mem_sel_n && mem_sel && !mem_we_n;
         rden = !mem_sel_n && mem_sel && mem_we_n && !mem_oe_n;
         chk(mem_sel_n == !mem_sel, "R1 select pair", mem_sel_n, !mem_sel);
         chk(!(mem_dq_oe && !mem_oe_n), "R6 bus contention", mem_dq_oe, 0);
         if (req_ready)
            chk(mem_sel_n && !mem_sel && mem_we_n && mem_oe_n && !mem_dq_oe,
                "R1 idle strobes", {mem_sel_n, mem_sel, mem_we_n, mem_oe_n, mem_dq_oe}, 5'b10110);
         if (mem_dq_oe && mem_we_n)
            chk(!mem_sel_n && mem_sel, "R8 selects held in recovery", mem_sel, 1);
         if (win) begin
            chk(mem_dq_oe, "R4 bus driven in window", mem_dq_oe, 1);
            if (prev_win) begin
               chk(mem_addr == win_addr, "R3 address stable", mem_addr, win_addr);
               chk(mem_dq_out == win_data, "R3 data stable", mem_dq_out, win_data);
            end
            win_addr = mem_addr;
            win_data = mem_dq_out;
            we_run++;
         end else if (prev_win) begin
            chk(we_run == WP, "R3 window length", we_run, WP);
            chk(mem_dq_oe, "R4 data held after window", mem_dq_oe, 1);
            model_mem[win_addr] = win_data;
            we_run = 0;
         end
         if (rden && !prev_rd && drove)
            chk(since_drive >= TURN, "R7 write-to-read gap", since_drive, TURN);
         if (mem_dq_oe && !prev_dqoe && seen_oe)
            chk(since_oe >= TURN, "R7 read-to-write gap", since_oe, TURN);
         ended = !rden && prev_rd;
         if (rden) begin
            oe_run++;
            mem_dq_in = model_mem.exists(mem_addr) ? model_mem[mem_addr] : 8'h00;
         end else begin
            mem_dq_in = 8'hEE;
         end
         if (ended) begin
            chk(oe_run == RD, "R5 read strobe length", oe_run, RD);
            oe_run = 0;
         end
         chk(rd_valid == ended, "R9 valid pulse timing", rd_valid, ended);
         if (rd_valid) begin
            if (exp_q.size() == 0) chk(1'b0, "R9 unexpected read data", rd_data, 0);
            else begin
               logic [7:0] e;
               e = exp_q.pop_front();
               chk(rd_data == e, "R9 read data", rd_data, e);
            end
         end
         if (mem_dq_oe) begin since_drive = 0; drove = 1; end else since_drive++;
         if (rden) begin since_oe = 0; seen_oe = 1; end else since_oe++;
         prev_win  = win;
         prev_rd   = rden;
         prev_dqoe = mem_dq_oe;
      end
   end

   // ---------------- request driver ----------------
   bit have_last = 0, last_dir = 0;

   task automatic issue(input bit wr, input logic [17:0] a, input logic [7:0] d, input int linger);
      int busy, k, expb;
      bit turn;
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      turn = have_last && (last_dir != wr);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
      if (wr) shadow[a] = d;
      else exp_q.push_back(shadow.exists(a) ? shadow[a] : 8'h00);
      have_last = 1; last_dir = wr;
      @(negedge clk);
      chk(!req_ready, "R2 ready drops after take", req_ready, 0);
      busy = 1; k = 0;
      while (1) begin
         if (k < linger) begin
            // request offered while busy: must be ignored (R2)
            req_valid = 1'b1; req_write = 1'b1; req_addr = a ^ 18'h000F0; req_wdata = ~d;
         end else begin
            req_valid = 1'b0;
         end
         @(negedge clk);
         k++;
         if (req_ready) break;
         busy++;
      end
      req_valid = 1'b0;
      expb = (turn ? TURN : 0) + (wr ? WC : RD);
      if (wr) chk(busy == expb, "R4 write busy cycles (R7 gap included)", busy, expb);
      else    chk(busy == expb, "R5 read busy cycles (R7 gap included)", busy, expb);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(req_ready && mem_sel_n && !mem_sel && mem_we_n && mem_oe_n && !mem_dq_oe && !rd_valid,
          "R1 reset state", {req_ready, mem_sel_n, mem_sel, mem_we_n, mem_oe_n, mem_dq_oe, rd_valid}, 7'b1101100);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      issue(1, 18'h00000, 8'hA5, 0);
      issue(1, 18'h3FFFF, 8'h5A, 0);
      issue(1, 18'h12345, 8'hC3, 0);
      issue(1, 18'h001F0, 8'h22, 0);
      issue(1, 18'h00100, 8'h11, 3);   // R2: offers write 0x001F0 <- 0xEE while busy
      issue(0, 18'h00000, 8'h00, 0);
      issue(0, 18'h3FFFF, 8'h00, 0);
      issue(0, 18'h12345, 8'h00, 0);
      issue(0, 18'h001F0, 8'h00, 0);   // R2: still 0x22
      issue(0, 18'h00100, 8'h00, 0);
      issue(1, 18'h12345, 8'h0F, 0);
      issue(0, 18'h12345, 8'h00, 0);
      for (int i = 0; i < 16; i++) issue(1, 18'((i * 18'h3333) & 18'h3FFFF), 8'(i * 37 + 1), 0);
      for (int i = 15; i >= 0; i--) issue(0, 18'((i * 18'h3333) & 18'h3FFFF), 8'h00, 0);
      for (int i = 0; i < 4; i++) begin
         issue(1, 18'(i + 18'h20000), 8'(8'h80 | i), 0);
         issue(0, 18'(i + 18'h20000), 8'h00, 0);
      end
      repeat (12) @(negedge clk);
      chk(exp_q.size() == 0, "R9 all reads returned", exp_q.size(), 0);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         fails++; tests++;
         $display("FAIL R2 watchdog actual=hung expected=finished");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

endmodule